// File: doc/BRIEF.md
# Masked Vector Integer ALU

This block runs the single-width integer vector operations of a vector unit across a fixed number of lanes. Each lane holds an element `SEW` bits wide. A decoded instruction arrives in one cycle together with its operands: the major opcode, the `funct6` and `funct3` fields, the mask-enable bit, the `vs2` element vector, a `vs1` element vector, a shared scalar and a 5-bit immediate. The current destination contents and one mask bit per lane, taken from the LSB of the mask register element, arrive in the same cycle.

The `funct3` category picks the second operand for all lanes. The `funct6` field picks one of these operations:

- add, subtract and reverse subtract, all modular;
- bitwise AND, OR and XOR;
- logical left shift, logical right shift and arithmetic right shift;
- eight compares that write a single mask bit.

The block registers the result vector and raises `out_valid` one cycle after `in_valid`. A lane that is masked off keeps its old destination value. An unsupported encoding raises `illegal` and leaves every lane unchanged.

Top module: `vec_int_alu`

## Requirements
- R1: `out_valid` is 1 in the cycle after a cycle with `in_valid` high, and 0 in the cycle after a cycle with `in_valid` low. `vd_new` and `illegal` are valid while `out_valid` is 1.
- R2: The operand source is set by `funct3`, the same for every lane. `000` uses the `vs1` element of that lane. `100` uses `scalar`. `011` uses the extended `imm5`. `vs2` is always the first operand.
- R3: The arithmetic and logic codes are add `000000` (vs2+op), sub `000010` (vs2-op), reverse sub `000011` (op-vs2), and `001001`, or `001010`, xor `001011`. All results are modulo 2^SEW.
- R4: The immediate is sign-extended to SEW for every operation except these three cases, where it is zero-extended: the shifts, unsigned less-or-equal `011100`, and unsigned greater-than `011110`. As a result, xor with immediate `11111` gives the bitwise NOT of vs2.
- R5: The shift codes are sll `100101`, srl `101000` and sra `101001`. Each uses only the low log2(SEW) bits of its amount. srl fills with zeros and sra copies the sign bit of vs2.
- R6: The compare codes are eq `011000`, ne `011001`, ltu `011010`, lt `011011`, leu `011100`, le `011101`, gtu `011110` and gt `011111`. The signed forms compare in two's complement. The result goes into bit 0 of the element, and all higher bits are 0.
- R7: When `vm` is 0, a lane whose `v0_lsb` bit is 0 returns its `vd_old` element unchanged. When `vm` is 1, every lane takes the computed result.
- R8: `illegal` is 1, and `vd_new` equals `vd_old` in every lane, in any of these cases:
  - `opcode` is not `1010111`;
  - `funct3` is not `000`, `011` or `100`;
  - `funct6` is outside R3, R5 and R6;
  - sub, ltu or lt is used with `funct3` `011`;
  - reverse sub, gtu or gt is used with `funct3` `000`.
- R9: While `rst_n` is low, `out_valid`, `illegal` and `vd_new` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands present |
| opcode | input | 7 | Major opcode |
| funct6 | input | 6 | Operation select |
| funct3 | input | 3 | Operand category |
| vm | input | 1 | 1 = unmasked, 0 = masked by v0_lsb |
| vs2 | input | LANES*SEW | First operand elements |
| vs1 | input | LANES*SEW | Second operand elements (vector form) |
| scalar | input | SEW | Shared scalar operand |
| imm5 | input | 5 | Immediate operand |
| vd_old | input | LANES*SEW | Current destination elements |
| v0_lsb | input | LANES | Mask bit per lane |
| out_valid | output | 1 | Result present |
| illegal | output | 1 | Unsupported encoding |
| vd_new | output | LANES*SEW | Result elements |

## Verification
Every result is due exactly one clock edge after the edge that samples `in_valid`. This applies to the lane values, the mask and compare outcomes, and the illegal flag. The bench drives a complete instruction on a falling edge. It then compares `out_valid`, `illegal` and every lane of `vd_new` on the next falling edge, so each check sits half a period after the register update. After an idle cycle it also confirms that `out_valid` has dropped.

// File: rtl/vec_int_alu.sv
module vec_int_alu #(
  parameter int LANES = 4,
  parameter int SEW   = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [6:0]             opcode,
  input  logic [5:0]             funct6,
  input  logic [2:0]             funct3,
  input  logic                   vm,
  input  logic [LANES*SEW-1:0]   vs2,
  input  logic [LANES*SEW-1:0]   vs1,
  input  logic [SEW-1:0]         scalar,
  input  logic [4:0]             imm5,
  input  logic [LANES*SEW-1:0]   vd_old,
  input  logic [LANES-1:0]       v0_lsb,
  output logic                   out_valid,
  output logic                   illegal,
  output logic [LANES*SEW-1:0]   vd_new
);
  localparam int SH = $clog2(SEW);

  wire is_vv = funct3 == 3'b000;
  wire is_vi = funct3 == 3'b011;
  wire is_vs = funct3 == 3'b100;
  wire op_ok = opcode == 7'b1010111;

  wire imm_zext = (funct6 == 6'b011100) || (funct6 == 6'b011110) ||
                  (funct6 == 6'b100101) || (funct6 == 6'b101000) ||
                  (funct6 == 6'b101001);
  wire [SEW-1:0] imm_ext = imm_zext ? {{(SEW-5){1'b0}}, imm5}
                                    : {{(SEW-5){imm5[4]}}, imm5};

  logic legal;
  always_comb begin
    case (funct6)
      6'b000000, 6'b001001, 6'b001010, 6'b001011,
      6'b100101, 6'b101000, 6'b101001,
      6'b011000, 6'b011001, 6'b011100, 6'b011101:
        legal = is_vv | is_vi | is_vs;
      6'b000010, 6'b011010, 6'b011011:
        legal = is_vv | is_vs;
      6'b000011, 6'b011110, 6'b011111:
        legal = is_vi | is_vs;
      default: legal = 1'b0;
    endcase
    legal = legal & op_ok;
  end

  logic [LANES*SEW-1:0] nxt;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wire [SEW-1:0] a = vs2[i*SEW +: SEW];
    wire [SEW-1:0] b = is_vv ? vs1[i*SEW +: SEW] : (is_vs ? scalar : imm_ext);
    wire [SH-1:0]  sh = b[SH-1:0];
    logic [SEW-1:0] r;
    logic c;
    always_comb begin
      case (funct6)
        6'b011000: c = a == b;
        6'b011001: c = a != b;
        6'b011010: c = a < b;
        6'b011011: c = $signed(a) < $signed(b);
        6'b011100: c = a <= b;
        6'b011101: c = $signed(a) <= $signed(b);
        6'b011110: c = a > b;
        default:   c = $signed(a) > $signed(b);
      endcase
      case (funct6)
        6'b000000: r = a + b;
        6'b000010: r = a - b;
        6'b000011: r = b - a;
        6'b001001: r = a & b;
        6'b001010: r = a | b;
        6'b001011: r = a ^ b;
        6'b100101: r = a << sh;
        6'b101000: r = a >> sh;
        6'b101001: r = $signed(a) >>> sh;
        default:   r = {{(SEW-1){1'b0}}, c};
      endcase
    end
    assign nxt[i*SEW +: SEW] = (!legal || (!vm && !v0_lsb[i])) ? vd_old[i*SEW +: SEW] : r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      vd_new    <= '0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid & ~legal;
      if (in_valid) vd_new <= nxt;
    end
  end
endmodule

// File: rtl/vec_int_alu_chk.sv
module vec_int_alu_chk #(
  parameter int LANES = 4,
  parameter int SEW   = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [6:0]           opcode,
  input logic                 vm,
  input logic [LANES-1:0]     v0_lsb,
  input logic [LANES*SEW-1:0] vd_old,
  input logic                 out_valid,
  input logic                 illegal,
  input logic [LANES*SEW-1:0] vd_new
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_flag_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> out_valid);
  a_r8_bad_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode != 7'b1010111) |=> illegal);
  a_r8_keep_all: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid) |=> (!illegal || vd_new == $past(vd_old)));
  for (genvar i = 0; i < LANES; i++) begin : g_m
    a_r7_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !vm && !v0_lsb[i]) |=> vd_new[i*SEW +: SEW] == $past(vd_old[i*SEW +: SEW]));
  end
endmodule

bind vec_int_alu vec_int_alu_chk #(.LANES(LANES), .SEW(SEW)) chk_i (.*);

// File: tb/vec_int_alu_tb.sv
module vec_int_alu_tb_top;
  localparam int L = 4;
  localparam int W = 32;

  logic clk = 0, rst_n = 0, in_valid = 0, vm = 1;
  logic [6:0] opcode = 7'b1010111;
  logic [5:0] funct6 = 0;
  logic [2:0] funct3 = 0;
  logic [L*W-1:0] vs2 = 0, vs1 = 0, vd_old = 0;
  logic [W-1:0] scalar = 0;
  logic [4:0] imm5 = 0;
  logic [L-1:0] v0_lsb = 0;
  logic out_valid, illegal;
  logic [L*W-1:0] vd_new;

  int tests = 0, fails = 0;

  vec_int_alu #(.LANES(L), .SEW(W)) dut_i (.*);

  always #10 clk = ~clk;

  function automatic logic legal_ref(logic [6:0] opc, logic [5:0] f6, logic [2:0] f3);
    logic vv = f3 == 3'b000, vi = f3 == 3'b011, vs = f3 == 3'b100;
    if (opc != 7'b1010111 || !(vv || vi || vs)) return 0;
    if (f6 inside {6'b000010, 6'b011010, 6'b011011}) return !vi;
    if (f6 inside {6'b000011, 6'b011110, 6'b011111}) return !vv;
    return f6 inside {6'b000000, 6'b001001, 6'b001010, 6'b001011, 6'b100101,
                      6'b101000, 6'b101001, 6'b011000, 6'b011001, 6'b011100, 6'b011101};
  endfunction

  function automatic logic [W-1:0] lane_ref(logic [5:0] f6, logic [2:0] f3, logic [W-1:0] a,
                                            logic [W-1:0] v1, logic [W-1:0] sc, logic [4:0] im);
    logic [W-1:0] b;
    int unsigned s;
    logic signed [W-1:0] sa, sb;
    if (f3 == 3'b000) b = v1;
    else if (f3 == 3'b100) b = sc;
    else if (f6 inside {6'b011100, 6'b011110, 6'b100101, 6'b101000, 6'b101001})
      b = W'(im);
    else b = W'($signed(im));
    s = b % W;
    sa = a; sb = b;
    case (f6)
      6'b000000: return a + b;
      6'b000010: return a - b;
      6'b000011: return b - a;
      6'b001001: return a & b;
      6'b001010: return a | b;
      6'b001011: return a ^ b;
      6'b100101: return a << s;
      6'b101000: return a >> s;
      6'b101001: return sa >>> s;
      6'b011000: return W'(a == b);
      6'b011001: return W'(a != b);
      6'b011010: return W'(a < b);
      6'b011011: return W'(sa < sb);
      6'b011100: return W'(a <= b);
      6'b011101: return W'(sa <= sb);
      6'b011110: return W'(a > b);
      default:   return W'(sa > sb);
    endcase
  endfunction

  task automatic check(string tag, logic [L*W-1:0] act, logic [L*W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(string tag);
    logic [L*W-1:0] e;
    logic lg;
    lg = legal_ref(opcode, funct6, funct3);
    for (int i = 0; i < L; i++)
      e[i*W +: W] = (!lg || (!vm && !v0_lsb[i])) ? vd_old[i*W +: W]
                  : lane_ref(funct6, funct3, vs2[i*W +: W], vs1[i*W +: W], scalar, imm5);
    in_valid = 1;
    @(negedge clk);
    check({tag, " R1 valid"}, L*W'(out_valid), L*W'(1'b1));
    check({tag, " R8 flag"}, L*W'(illegal), L*W'(!lg));
    check({tag, " data"}, vd_new, e);
    in_valid = 0;
  endtask

  task automatic set_op(logic [5:0] f6, logic [2:0] f3, logic [L*W-1:0] a,
                        logic [L*W-1:0] b, logic [W-1:0] sc, logic [4:0] im);
    funct6 = f6; funct3 = f3; vs2 = a; vs1 = b; scalar = sc; imm5 = im;
  endtask

  function automatic logic [W-1:0] rnd_val();
    case ($urandom_range(0, 5))
      0: return '0;
      1: return '1;
      2: return {1'b1, {(W-1){1'b0}}};
      3: return W'($urandom_range(0, 40));
      default: return $urandom();
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [5:0] ops [17];
    ops = '{6'b000000, 6'b000010, 6'b000011, 6'b001001, 6'b001010, 6'b001011,
            6'b100101, 6'b101000, 6'b101001, 6'b011000, 6'b011001, 6'b011010,
            6'b011011, 6'b011100, 6'b011101, 6'b011110, 6'b011111};
    void'($urandom(32'd4242));
    vd_old = {4{32'hDEAD_BEEF}};
    repeat (3) @(negedge clk);
    check("R9 reset out", {vd_new, out_valid, illegal}, '0);
    rst_n = 1;
    @(negedge clk);

    // R2/R3 add vv vs vi
    set_op(6'b000000, 3'b000, {32'd1, 32'd2, 32'hFFFFFFFF, 32'd7}, {32'd10, 32'd20, 32'd1, 32'd3}, 0, 0);
    run_op("R2 R3 add vv");
    set_op(6'b000011, 3'b100, {32'd1, 32'd2, 32'd3, 32'd4}, 0, 32'd100, 0);
    run_op("R3 rsub vs");
    set_op(6'b000000, 3'b011, {32'd1, 32'd0, 32'd5, 32'd9}, 0, 0, 5'b10000);
    run_op("R4 add vi negative");
    // R4 xor -1 gives NOT
    set_op(6'b001011, 3'b011, {32'h12345678, 32'h0, 32'hFFFFFFFF, 32'h80000001}, 0, 0, 5'b11111);
    run_op("R4 not");
    check("R4 not value", vd_new, ~{32'h12345678, 32'h0, 32'hFFFFFFFF, 32'h80000001});
    // R5 shifts with large amount
    set_op(6'b100101, 3'b100, {4{32'h0000_0003}}, 0, 32'd33, 0);
    run_op("R5 sll low bits");
    set_op(6'b101001, 3'b011, {4{32'h8000_0000}}, 0, 0, 5'd31);
    run_op("R5 sra sign");
    set_op(6'b101000, 3'b000, {4{32'h8000_0000}}, {32'd31, 32'd32, 32'd1, 32'd63}, 0, 0);
    run_op("R5 srl");
    // R6 compares: leu.vi unsigned 31, gt.vi signed -1
    set_op(6'b011100, 3'b011, {32'd31, 32'd32, 32'hFFFFFFFF, 32'd0}, 0, 0, 5'b11111);
    run_op("R6 leu vi");
    set_op(6'b011111, 3'b011, {32'd0, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h80000000}, 0, 0, 5'b11111);
    run_op("R6 gt vi");
    set_op(6'b011011, 3'b000, {32'h80000000, 32'd1, 32'd5, 32'd5}, {32'd0, 32'hFFFFFFFF, 32'd5, 32'd6}, 0, 0);
    run_op("R6 lt vv");
    // R7 masking
    vm = 0; v0_lsb = 4'b0101;
    set_op(6'b001010, 3'b100, {4{32'h0000_00F0}}, 0, 32'h0000_000F, 0);
    run_op("R7 masked or");
    vm = 1;
    // R8 illegal forms
    set_op(6'b000010, 3'b011, {4{32'd9}}, 0, 0, 5'd1);
    run_op("R8 sub vi");
    set_op(6'b000011, 3'b000, {4{32'd9}}, 0, 0, 0);
    run_op("R8 rsub vv");
    set_op(6'b000000, 3'b001, {4{32'd9}}, 0, 0, 0);
    run_op("R8 funct3");
    opcode = 7'b0000111;
    set_op(6'b000000, 3'b000, {4{32'd9}}, {4{32'd1}}, 0, 0);
    run_op("R8 opcode");
    opcode = 7'b1010111;
    @(negedge clk);
    check("R1 idle", L*W'(out_valid), '0);

    for (int n = 0; n < 400; n++) begin
      logic [L*W-1:0] a, b, o;
      for (int i = 0; i < L; i++) begin
        a[i*W +: W] = rnd_val(); b[i*W +: W] = rnd_val(); o[i*W +: W] = $urandom();
      end
      vd_old = o;
      vm = $urandom_range(0, 1);
      v0_lsb = L'($urandom());
      opcode = ($urandom_range(0, 19) == 0) ? 7'h33 : 7'b1010111;
      case ($urandom_range(0, 9))
        0: funct3 = 3'($urandom());
        1, 2, 3: funct3 = 3'b000;
        4, 5, 6: funct3 = 3'b011;
        default: funct3 = 3'b100;
      endcase
      set_op(($urandom_range(0, 15) == 0) ? 6'($urandom()) : ops[$urandom_range(0, 16)],
             funct3, a, b, rnd_val(), 5'($urandom()));
      run_op("R2 R3 R4 R5 R6 R7 R8 random");
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        check("R1 gap", L*W'(out_valid), '0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule